// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that owns a small bank of 8-bit configuration registers and drives a few control outputs from the first of them. The clock and data lines are brought into the system clock domain through two-stage synchronizers, and the block finds start and stop conditions by watching the data line while the clock line is high. The data line is open-drain. The block models it with one output-enable that pulls the line low when set.

There is no sub-addressing. A write names the device, sends a command byte and a count byte that are acknowledged and then discarded, and then fills the registers in order starting from register 0. A read names the device and gets back a fixed byte count equal to the number of registers, then the registers in order starting from register 0. After each byte the slave waits for the master's acknowledge, and a not-acknowledge ends the read.

Register 0 controls the outputs. Bit 3 picks the frequency source. When it is 0 the 5-bit hardware select pins pass straight through. When it is 1 a code taken from bits spread across the register is used instead. Bit 1 turns on spread spectrum and bit 0 selects test mode.

Top module: `smb_cfg_slave`

## Requirements
- R1: A falling SDA with SCL high is a start and a rising SDA with SCL high is a stop. Either one is honoured at any point, including in the middle of a byte. A start always restarts address decoding with the register index at 0. A stop returns the block to idle with SDA released.
- R2: The first byte after a start is answered with an acknowledge only for 0xD2 (write) and 0xD3 (read). Any other value gets no acknowledge, and the block leaves SDA alone until the next start.
- R3: Bytes travel MSB first. An acknowledge from the slave holds SDA low through the ninth SCL pulse, and the slave changes SDA only while SCL is low.
- R4: In a write, the two bytes that follow the address are acknowledged and their contents change no register.
- R5: In a write, the bytes after those two are acknowledged and stored in registers 0, 1, 2, and so on, always starting from register 0.
- R6: A read returns first the byte count, which is the number of registers (4 by default), and then registers 0, 1, 2, and so on. Each byte after the first is sent only after the master acknowledges.
- R7: A master not-acknowledge during a read makes the slave release SDA and send nothing more until the next start, so the lines read 0xFF.
- R8: At most 10 data bytes move in one access. The 11th written data byte gets no acknowledge and is not stored. After the 10th register byte of a read, SDA stays released. Written data aimed past the last register is discarded, and reads of those positions return 0x00.
- R9: After reset all registers are 0, ss_en and test_mode are 0, fsel equals hw_fsel, and SDA is released.
- R10: When register 0 bit 3 is 0, fsel follows hw_fsel. When it is 1, fsel[4:0] = {bit7, bit2, bit6, bit5, bit4} of register 0.
- R11: ss_en equals register 0 bit 1 and test_mode equals register 0 bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | When 1, the slave pulls the data line low |
| hw_fsel | input | 5 | Frequency select from the hardware pins |
| fsel | output | 5 | Frequency select in use |
| ss_en | output | 1 | Spread-spectrum enable |
| test_mode | output | 1 | Test mode flag |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except to make a start or stop, and every SCL high and low phase lasts well beyond the three-cycle synchronizer delay, so each edge is seen once and cleanly. The bench master holds every SCL phase for twelve system clocks. It changes its lines only on the falling system clock edge, and it moves SDA with SCL high only inside its start and stop tasks. Mid-byte aborts are still made of legal conditions.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NREGS     = 4,
  parameter int         MAX_BYTES = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [4:0] hw_fsel,
  output logic [4:0] fsel,
  output logic       ss_en,
  output logic       test_mode
);

  localparam int IW = $clog2(MAX_BYTES + 1);
  localparam int RW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [IW-1:0] LIMIT_W    = IW'(MAX_BYTES);
  localparam logic [IW-1:0] NREGS_W    = IW'(NREGS);
  localparam logic [7:0]    BYTE_COUNT = 8'(NREGS);

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_RX   = 3'd1;
  localparam logic [2:0] ST_ACK  = 3'd2;
  localparam logic [2:0] ST_TX   = 3'd3;
  localparam logic [2:0] ST_MACK = 3'd4;

  logic [1:0] scl_m, sda_m;
  logic       scl_d, sda_d;
  logic       scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_d <= scl_m[1];
      sda_d <= sda_m[1];
    end
  end

  assign scl_s = scl_m[1];
  assign sda_s = sda_m[1];

  logic start_c, stop_c, scl_rise, scl_fall;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;

  logic [2:0]    st;
  logic [3:0]    bitcnt;
  logic [7:0]    sr;
  logic [1:0]    byte_no;
  logic          rw;
  logic [IW-1:0] idx;
  logic [7:0]    regs [NREGS];
  logic [7:0]    rd_byte;
  logic [7:0]    r0;
  logic          addr_hit;

  assign rd_byte  = (idx < NREGS_W) ? regs[idx[RW-1:0]] : 8'h00;
  assign addr_hit = (sr[7:1] == DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bitcnt  <= 4'd0;
      sr      <= 8'h00;
      byte_no <= 2'd0;
      rw      <= 1'b0;
      idx     <= '0;
      sda_oe  <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= 8'h00;
    end else if (start_c) begin
      st      <= ST_RX;
      bitcnt  <= 4'd0;
      byte_no <= 2'd0;
      idx     <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_c) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            sr     <= {sr[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (byte_no == 2'd0) begin
              if (addr_hit) begin
                rw     <= sr[0];
                sda_oe <= 1'b1;
                st     <= ST_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else if (byte_no != 2'd3) begin
              sda_oe <= 1'b1;
              st     <= ST_ACK;
            end else if (idx != LIMIT_W) begin
              if (idx < NREGS_W) regs[idx[RW-1:0]] <= sr;
              idx    <= idx + IW'(1);
              sda_oe <= 1'b1;
              st     <= ST_ACK;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= 4'd0;
            if (byte_no != 2'd3) byte_no <= byte_no + 2'd1;
            if (rw && byte_no == 2'd0) begin
              sr     <= BYTE_COUNT;
              sda_oe <= ~BYTE_COUNT[7];
              st     <= ST_TX;
            end else begin
              st <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              st     <= ST_MACK;
            end else begin
              sr     <= {sr[6:0], 1'b0};
              sda_oe <= ~sr[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise && sda_s) begin
            st <= ST_IDLE;
          end else if (scl_fall) begin
            if (idx == LIMIT_W) begin
              st <= ST_IDLE;
            end else begin
              sr     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              bitcnt <= 4'd0;
              idx    <= idx + IW'(1);
              st     <= ST_TX;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign r0        = regs[0];
  assign fsel      = r0[3] ? {r0[7], r0[2], r0[6], r0[5], r0[4]} : hw_fsel;
  assign ss_en     = r0[1];
  assign test_mode = r0[0];

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_d,
  input logic       sda_s,
  input logic       start_c,
  input logic       stop_c,
  input logic [2:0] st,
  input logic       sda_oe,
  input logic [7:0] r0,
  input logic [4:0] hw_fsel,
  input logic [4:0] fsel
);

  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_RX   = 3'd1;
  localparam logic [2:0] C_TX   = 3'd3;
  localparam logic [2:0] C_MACK = 3'd4;

  logic rise_seen;
  assign rise_seen = scl_s & ~scl_d;

  a_r3_drive_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == C_IDLE && !sda_oe));

  a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == C_RX && !sda_oe));

  a_r7_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_MACK && rise_seen && sda_s) |=> (st == C_IDLE && !sda_oe));

  a_r6_read_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_TX || st == C_MACK) |=> $stable(r0));

  a_r10_hw_path_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!r0[3] && $past(!r0[3]) && $stable(hw_fsel)) |-> $stable(fsel));

endmodule

bind smb_cfg_slave smb_cfg_slave_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_s   (scl_s),
  .scl_d   (scl_d),
  .sda_s   (sda_s),
  .start_c (start_c),
  .stop_c  (stop_c),
  .st      (st),
  .sda_oe  (sda_oe),
  .r0      (r0),
  .hw_fsel (hw_fsel),
  .fsel    (fsel)
);

// File: tb/smb_cfg_slave_tb.sv
module smb_cfg_slave_tb_top;

  localparam int H = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [4:0] hw_fsel = 5'h0A;
  logic [4:0] fsel;
  logic       ss_en, test_mode;
  wire        sda = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_regs [4];
  logic [7:0] wbuf [12];
  logic       oe_seen = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) if (sda_oe) oe_seen <= 1'b1;

  smb_cfg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .hw_fsel(hw_fsel), .fsel(fsel), .ss_en(ss_en), .test_mode(test_mode)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(H); scl = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl = 1'b0; hw(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(H); scl = 1'b1; hw(H); sda_m = 1'b1; hw(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hw(H); scl = 1'b1; hw(H); scl = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; hw(H); scl = 1'b1; hw(H/2); b = sda; hw(H/2); scl = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(s);
    ack = !s;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) recv_bit(b[i]);
    send_bit(!ack);
  endtask

  function automatic logic [7:0] exp_at(input int i);
    return (i < 4) ? exp_regs[i] : 8'h00;
  endfunction

  // full write access: address, two header bytes, n data bytes from wbuf
  task automatic write_xfer(input string req, input int n, input logic [7:0] cmd, input logic [7:0] cnt);
    logic ack;
    bus_start();
    wr_byte(8'hD2, ack); chk("R2", "write address ack", ack, 1);
    wr_byte(cmd, ack);   chk("R4", "command byte ack", ack, 1);
    wr_byte(cnt, ack);   chk("R4", "count byte ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], ack);
      chk(i < 10 ? req : "R8", "data byte ack", ack, (i < 10) ? 1 : 0);
      if (i < 4) exp_regs[i] = wbuf[i];
    end
    bus_stop();
  endtask

  // read count plus n registers, acknowledge all but the last
  task automatic read_xfer(input string req, input int n);
    logic ack;
    logic [7:0] b;
    bus_start();
    wr_byte(8'hD3, ack); chk("R2", "read address ack", ack, 1);
    rd_byte(b, n != 0);  chk("R6", "byte count", b, 8'h04);
    for (int i = 0; i < n; i++) begin
      rd_byte(b, i != n - 1);
      chk(req, $sformatf("register %0d (R3 MSB first)", i), b, exp_at(i));
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R9", "sda_oe after reset", sda_oe, 0);
    chk("R9", "ss_en after reset", ss_en, 0);
    chk("R9", "test_mode after reset", test_mode, 0);
    chk("R9", "fsel after reset", fsel, hw_fsel);
    read_xfer("R9", 4);
  endtask

  task automatic t_sw_select();
    wbuf[0] = 8'h9B; wbuf[1] = 8'h11; wbuf[2] = 8'h22; wbuf[3] = 8'h33;
    write_xfer("R5", 4, 8'h55, 8'hAA);
    hw(4);
    chk("R10", "software fsel", fsel, 5'h11);
    chk("R11", "ss_en", ss_en, 1);
    chk("R11", "test_mode", test_mode, 1);
    read_xfer("R5", 4);
  endtask

  task automatic t_hw_select();
    wbuf[0] = 8'h04;
    write_xfer("R5", 1, 8'hFF, 8'hFF);
    hw(4);
    chk("R10", "hardware fsel", fsel, 5'h0A);
    hw_fsel = 5'h15; hw(2);
    chk("R10", "hardware fsel follows pins", fsel, 5'h15);
    chk("R11", "ss_en cleared", ss_en, 0);
    chk("R11", "test_mode cleared", test_mode, 0);
    read_xfer("R5", 4);
  endtask

  task automatic t_header_only();
    write_xfer("R4", 0, 8'h9B, 8'h01);
    read_xfer("R4", 4);
  endtask

  task automatic t_bad_addr();
    logic ack;
    oe_seen = 1'b0;
    bus_start();
    wr_byte(8'hA0, ack); chk("R2", "foreign address nack", ack, 0);
    wr_byte(8'h9B, ack); chk("R2", "later byte ignored", ack, 0);
    bus_stop();
    bus_start();
    wr_byte(8'hD4, ack); chk("R2", "neighbour address nack", ack, 0);
    bus_stop();
    chk("R2", "SDA never pulled", oe_seen, 0);
    read_xfer("R2", 4);
  endtask

  task automatic t_nack_release();
    logic ack;
    logic [7:0] b;
    bus_start();
    wr_byte(8'hD3, ack); chk("R2", "read address ack", ack, 1);
    rd_byte(b, 1'b0);    chk("R6", "byte count", b, 8'h04);
    rd_byte(b, 1'b1);    chk("R7", "released after nack", b, 8'hFF);
    bus_stop();
  endtask

  task automatic t_overflow();
    logic ack;
    logic [7:0] b;
    for (int i = 0; i < 11; i++) wbuf[i] = 8'hA1 + 8'(i);
    write_xfer("R5", 11, 8'h00, 8'h00);
    hw(4);
    chk("R10", "fsel with bit3 clear", fsel, hw_fsel);
    chk("R11", "test_mode from A1", test_mode, 1);
    bus_start();
    wr_byte(8'hD3, ack); chk("R2", "read address ack", ack, 1);
    rd_byte(b, 1'b1);    chk("R6", "byte count", b, 8'h04);
    for (int i = 0; i < 10; i++) begin
      rd_byte(b, 1'b1);
      chk("R8", $sformatf("register %0d", i), b, exp_at(i));
    end
    rd_byte(b, 1'b0);    chk("R8", "released after 10 bytes", b, 8'hFF);
    bus_stop();
  endtask

  task automatic t_abort();
    logic ack;
    logic [7:0] b;
    bus_start();
    wr_byte(8'hD2, ack); wr_byte(8'h00, ack); wr_byte(8'h00, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    read_xfer("R1", 1);
    bus_start();
    wr_byte(8'hD2, ack); wr_byte(8'h00, ack); wr_byte(8'h00, ack);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    bus_start();
    wr_byte(8'hD3, ack); chk("R1", "address after repeated start", ack, 1);
    rd_byte(b, 1'b1);    chk("R1", "count after repeated start", b, 8'h04);
    rd_byte(b, 1'b0);    chk("R1", "register 0 after repeated start", b, exp_regs[0]);
    bus_start();
    wr_byte(8'hD2, ack); wr_byte(8'h00, ack); wr_byte(8'h00, ack);
    wr_byte(8'h5C, ack); chk("R5", "first data ack", ack, 1);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    wr_byte(8'hD2, ack); wr_byte(8'h00, ack); wr_byte(8'h00, ack);
    wr_byte(8'h77, ack); chk("R1", "data after repeated start", ack, 1);
    bus_stop();
    exp_regs[0] = 8'h77;
    read_xfer("R1", 2);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) exp_regs[i] = 8'h00;
    hw(5);
    rst_n = 1'b1;
    hw(5);
    t_reset();
    t_sw_select();
    t_hw_select();
    t_header_only();
    t_bad_addr();
    t_nack_release();
    t_overflow();
    t_abort();
    hw(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule